// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a data cache placed between a processor load/store port and a main-memory port that moves whole lines. Each processor access carries an address, a read/write flag, write data and byte enables, and is held steady until the cache raises `cpu_ready`. Memory traffic is one line per request, under a request/acknowledge handshake. The request and acknowledge carry a write flag, a line-aligned address, and a line of data in each direction.

The address is cut into three fields: a byte offset, a set index and a tag. The tags of both ways in the indexed set are compared at once, and the way that hits drives the read word through a two-input multiplexer. Stores that hit stay in the cache and mark the line dirty. A miss picks the less recently used way of the set. If that line holds modified data, it is written to memory first. The missing line is then fetched, and one more cycle finishes the original access. Stores that miss allocate the line in the same way and then merge into it.

Top module: `cache_2way`

## Requirements
- R1: Address fields, least significant first: 4 bits of byte offset (word select in bits [3:2]), then 3 bits of set index, then the remaining 9 bits of tag. Every memory request carries a line-aligned address, with the offset bits zero.
- R2: A way hits only when its stored tag equals the address tag and its valid bit is 1. A hit in the idle state completes in the same cycle the request is presented, with no memory request.
- R3: At most one way hits. A read returns the 32-bit word picked by the word-select bits from the hitting way's line.
- R4: On a miss, the victim is the way of the indexed set that was not most recently read, written or refilled.
- R5: A store that hits updates only the cached line and marks it dirty. No memory request is made for it.
- R6: A victim that is valid and dirty is written to memory (write flag 1) at its own line address, with its current contents, before the refill. A clean or invalid victim is not written.
- R7: A store that misses first fetches the whole line from memory and then merges the store into it.
- R8: Bit i of `cpu_be` enables byte i (bits 8i+7:8i) of the stored word, on the hit path and on the allocate path. Bytes whose enable is 0 keep their previous value.
- R9: A miss proceeds idle, then write-back (only for a dirty victim), then refill, then one completing cycle. `cpu_ready` stays 0 until that completing cycle and is never 1 while a memory request is raised.
- R10: Synchronous reset clears every valid, dirty and LRU bit, so the first access to any address after reset misses.
- R11: Once raised, a memory request and its address stay steady until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor access valid, held until ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Byte enables for the store |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| cpu_ready | output | 1 | Access completes this cycle |
| mem_req | output | 1 | Line transfer request |
| mem_we | output | 1 | 1 = write back a line, 0 = fetch a line |
| mem_addr | output | 16 | Line-aligned memory address |
| mem_wline | output | 128 | Line being written back |
| mem_rline | input | 128 | Fetched line, valid with mem_ack |
| mem_ack | input | 1 | Memory completes the transfer this cycle |

## Verification
The bench aims at LRU replacement in a single set. It touches two tags, re-touches the first, then brings in a third. A design whose LRU bit is wrong evicts the hot line, and the next access to it misses where a hit is expected. Dirty victims are checked for a write-back carrying exactly the latest stored bytes. A design that skips the write-back, or writes back before the store has merged, leaves memory holding stale words, and a later reload reads them back. Partial byte enables on a write miss catch a merge that overwrites the fetched bytes. The first access after reset catches valid bits that were not cleared.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2,
    ST_DONE  = 2'd3
  } cache_state_e;
endpackage

// File: rtl/cache_way.sv
module cache_way #(
  parameter int TAG_W      = 9,
  parameter int IDX_W      = 3,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [IDX_W-1:0]              idx,
  input  logic [TAG_W-1:0]              lk_tag,
  input  logic                          fill_en,
  input  logic [WORD_W*LINE_WORDS-1:0]  fill_line,
  input  logic                          upd_en,
  input  logic [$clog2(LINE_WORDS)-1:0] upd_word,
  input  logic [WORD_W-1:0]             upd_data,
  input  logic [WORD_W/8-1:0]           upd_be,
  output logic                          hit,
  output logic [WORD_W*LINE_WORDS-1:0]  line_q,
  output logic [TAG_W-1:0]              tag_q,
  output logic                          valid_q,
  output logic                          dirty_q
);
  localparam int SETS   = 1 << IDX_W;
  localparam int LINE_W = WORD_W * LINE_WORDS;
  localparam int BYTES  = WORD_W / 8;

  logic [LINE_W-1:0] data_mem [SETS];
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [SETS-1:0]   valid_v;
  logic [SETS-1:0]   dirty_v;

  function automatic logic [WORD_W-1:0] merge_bytes(
    input logic [WORD_W-1:0] old_w, input logic [WORD_W-1:0] new_w,
    input logic [BYTES-1:0] be);
    logic [WORD_W-1:0] r;
    r = old_w;
    for (int b = 0; b < BYTES; b++)
      if (be[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
    return r;
  endfunction

  assign line_q  = data_mem[idx];
  assign tag_q   = tag_mem[idx];
  assign valid_q = valid_v[idx];
  assign dirty_q = dirty_v[idx];
  assign hit     = valid_q && (tag_q == lk_tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_v <= '0;
      dirty_v <= '0;
    end else if (fill_en) begin
      valid_v[idx] <= 1'b1;
      dirty_v[idx] <= 1'b0;
    end else if (upd_en) begin
      dirty_v[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      data_mem[idx] <= fill_line;
      tag_mem[idx]  <= lk_tag;
    end else if (upd_en) begin
      data_mem[idx][upd_word*WORD_W +: WORD_W] <=
        merge_bytes(data_mem[idx][upd_word*WORD_W +: WORD_W], upd_data, upd_be);
    end
  end

  // R7: a refill never coincides with a store merge into the same way
  p_fill_excl_upd_r7: assert property (@(posedge clk) disable iff (rst)
    fill_en |-> !upd_en);
  // R5: a store merge only lands on a line that already hits
  p_upd_needs_hit_r5: assert property (@(posedge clk) disable iff (rst)
    upd_en |-> hit);
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         req,
  input  logic         hit,
  input  logic         vict_dirty,
  input  logic         mem_ack,
  output cache_state_e state,
  output logic         mem_req,
  output logic         mem_we,
  output logic         fill_en,
  output logic         complete
);
  cache_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (req && !hit) nxt = vict_dirty ? ST_WBACK : ST_FILL;
      ST_WBACK: if (mem_ack) nxt = ST_FILL;
      ST_FILL:  if (mem_ack) nxt = ST_DONE;
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  assign mem_req  = (state == ST_WBACK) || (state == ST_FILL);
  assign mem_we   = (state == ST_WBACK);
  assign fill_en  = (state == ST_FILL) && mem_ack;
  assign complete = ((state == ST_IDLE) && req && hit) || (state == ST_DONE);

  // R9: the completing cycle of a miss always follows a refill
  p_done_after_fill_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |-> ($past(state) == ST_FILL));
  // R6: write-back is always followed by the refill
  p_wback_to_fill_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WBACK && mem_ack) |=> (state == ST_FILL));
endmodule

// File: rtl/cache_2way.sv
module cache_2way
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cpu_req,
  input  logic                         cpu_we,
  input  logic [ADDR_W-1:0]            cpu_addr,
  input  logic [WORD_W-1:0]            cpu_wdata,
  input  logic [WORD_W/8-1:0]          cpu_be,
  output logic [WORD_W-1:0]            cpu_rdata,
  output logic                         cpu_ready,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [WORD_W*LINE_WORDS-1:0] mem_wline,
  input  logic [WORD_W*LINE_WORDS-1:0] mem_rline,
  input  logic                         mem_ack
);
  localparam int BYTES  = WORD_W / 8;
  localparam int LINE_W = WORD_W * LINE_WORDS;
  localparam int BOFF_W = $clog2(BYTES);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int OFF_W  = BOFF_W + WSEL_W;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [IDX_W-1:0] addr_idx(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [WSEL_W-1:0] addr_word(input logic [ADDR_W-1:0] a);
    return a[BOFF_W +: WSEL_W];
  endfunction
  function automatic logic [ADDR_W-1:0] line_addr(input logic [TAG_W-1:0] t,
                                                  input logic [IDX_W-1:0] i);
    return {t, i, {OFF_W{1'b0}}};
  endfunction

  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx;
  logic [WSEL_W-1:0] a_word;
  assign a_tag  = addr_tag(cpu_addr);
  assign a_idx  = addr_idx(cpu_addr);
  assign a_word = addr_word(cpu_addr);

  logic [1:0]        way_hit;
  logic [1:0]        way_valid;
  logic [1:0]        way_dirty;
  logic [1:0]        way_fill;
  logic [1:0]        way_upd;
  logic [LINE_W-1:0] way_line [2];
  logic [TAG_W-1:0]  way_tag  [2];

  logic [SETS-1:0] lru_v;
  logic            victim;
  logic            hit, hit_way, vict_dirty;
  logic            fill_en, complete;
  cache_state_e    state;

  assign hit        = |way_hit;
  assign hit_way    = way_hit[1];
  assign victim     = lru_v[a_idx];
  assign vict_dirty = way_valid[victim] && way_dirty[victim];

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign way_fill[w] = fill_en && (victim == w[0]);
    assign way_upd[w]  = complete && cpu_we && way_hit[w];
    cache_way #(
      .TAG_W(TAG_W), .IDX_W(IDX_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)
    ) u_way (
      .clk(clk), .rst(rst), .idx(a_idx), .lk_tag(a_tag),
      .fill_en(way_fill[w]), .fill_line(mem_rline),
      .upd_en(way_upd[w]), .upd_word(a_word), .upd_data(cpu_wdata), .upd_be(cpu_be),
      .hit(way_hit[w]), .line_q(way_line[w]), .tag_q(way_tag[w]),
      .valid_q(way_valid[w]), .dirty_q(way_dirty[w])
    );
  end

  cache_ctrl u_ctrl (
    .clk(clk), .rst(rst), .req(cpu_req), .hit(hit), .vict_dirty(vict_dirty),
    .mem_ack(mem_ack), .state(state), .mem_req(mem_req), .mem_we(mem_we),
    .fill_en(fill_en), .complete(complete)
  );

  always_ff @(posedge clk) begin
    if (rst)           lru_v <= '0;
    else if (complete) lru_v[a_idx] <= ~hit_way;
    else if (fill_en)  lru_v[a_idx] <= ~victim;
  end

  assign cpu_ready = complete;
  assign cpu_rdata = way_line[hit_way][a_word*WORD_W +: WORD_W];
  assign mem_addr  = (state == ST_WBACK) ? line_addr(way_tag[victim], a_idx)
                                         : line_addr(a_tag, a_idx);
  assign mem_wline = way_line[victim];

  // R3: the two tag comparisons never both succeed
  p_single_hit_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(way_hit));
  // R6: a write-back only ever leaves for a valid dirty victim
  p_wb_dirty_only_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> vict_dirty);
  // R9: ready and memory traffic are mutually exclusive
  p_ready_quiet_mem_r9: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> !mem_req);
  // R11: request and address held until acknowledged
  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  // R1: memory addresses are line aligned
  p_line_align_r1: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[OFF_W-1:0] == '0));
  // R7: the completing cycle of a miss finds the line present
  p_done_hits_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |-> hit);
endmodule

// File: tb/sim_cache_2way.sv
module sim_cache_2way;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0]  cpu_addr = '0;
  logic [31:0]  cpu_wdata = '0;
  logic [3:0]   cpu_be = '0;
  logic [31:0]  cpu_rdata;
  logic         cpu_ready, mem_req, mem_we;
  logic [15:0]  mem_addr;
  logic [127:0] mem_wline;
  logic [127:0] mem_rline = '0;
  logic         mem_ack = 1'b0;

  always #4 clk = ~clk;

  cache_2way u0 (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wline(mem_wline),
    .mem_rline(mem_rline), .mem_ack(mem_ack)
  );

  int checks = 0, fails = 0;

  logic [31:0] ref_mem [1024];
  logic [31:0] dram    [1024];
  logic [8:0]  m_tag   [8][2];
  logic        m_val   [8][2];
  logic        m_dirty [8][2];
  logic        m_lru   [8];

  int          rd_cnt, wr_cnt, dly;
  logic [15:0] wb_addr;

  function automatic logic [8:0] b_tag(input logic [15:0] a); return a[15:7]; endfunction
  function automatic logic [2:0] b_set(input logic [15:0] a); return a[6:4];  endfunction
  function automatic logic [9:0] b_widx(input logic [15:0] a); return a[11:2]; endfunction
  function automatic logic [31:0] b_merge(input logic [31:0] o, input logic [31:0] n,
                                          input logic [3:0] be);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[k*8 +: 8] = be[k] ? n[k*8 +: 8] : o[k*8 +: 8];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // memory responder
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req && !rst) begin
      if (dly > 0) dly--;
      else begin
        if (mem_we) begin
          wr_cnt++;
          wb_addr = mem_addr;
          for (int k = 0; k < 4; k++) begin
            // R6: written-back words equal latest stored data
            check(mem_wline[k*32 +: 32] == ref_mem[{mem_addr[11:4], k[1:0]}], "R6 wb data",
                  mem_wline[k*32 +: 32], ref_mem[{mem_addr[11:4], k[1:0]}]);
            dram[{mem_addr[11:4], k[1:0]}] = mem_wline[k*32 +: 32];
          end
        end else begin
          rd_cnt++;
          for (int k = 0; k < 4; k++) mem_rline[k*32 +: 32] = dram[{mem_addr[11:4], k[1:0]}];
        end
        mem_ack = 1'b1;
        dly = int'($urandom % 3);
      end
    end
  end

  task automatic access(input bit we, input logic [15:0] a, input logic [31:0] wd,
                        input logic [3:0] be);
    logic [2:0] s;
    logic [8:0] t;
    bit exp_hit, exp_wb;
    logic way;
    logic [15:0] exp_wb_addr;
    int waits;
    s = b_set(a); t = b_tag(a);
    exp_hit = 0; exp_wb = 0; way = 0; exp_wb_addr = '0;
    for (int w = 0; w < 2; w++)
      if (m_val[s][w] && m_tag[s][w] == t) begin exp_hit = 1; way = w[0]; end
    if (!exp_hit) begin
      way = m_lru[s];
      exp_wb = m_val[s][way] && m_dirty[s][way];
      exp_wb_addr = {m_tag[s][way], s, 4'h0};
    end
    rd_cnt = 0; wr_cnt = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
    #1;
    waits = 0;
    while (!cpu_ready) begin @(negedge clk); #1; waits++; end
    // R2 R4 R10: hit/miss follows the reference LRU model
    check((waits == 0) == exp_hit, "R2/R4/R10 hit-miss", waits, exp_hit);
    if (!we)
      check(cpu_rdata == ref_mem[b_widx(a)], "R1/R3 rdata", cpu_rdata, ref_mem[b_widx(a)]);
    else begin
      ref_mem[b_widx(a)] = b_merge(ref_mem[b_widx(a)], wd, be);
      if (exp_hit) check(rd_cnt + wr_cnt == 0, "R5 no mem traffic", rd_cnt + wr_cnt, 0);
    end
    check(wr_cnt == int'(exp_wb), "R6 write-back count", wr_cnt, exp_wb);
    if (exp_wb) check(wb_addr == exp_wb_addr, "R6 wb address", wb_addr, exp_wb_addr);
    if (!exp_hit) check(rd_cnt == 1, "R7/R9 refill count", rd_cnt, 1);
    @(posedge clk);
    #1 cpu_req = 1'b0;
    if (!exp_hit) begin m_tag[s][way] = t; m_val[s][way] = 1; m_dirty[s][way] = 0; end
    if (we) m_dirty[s][way] = 1;
    m_lru[s] = ~way;
  endtask

  function automatic logic [15:0] mk(input int tg, input int st, input int wd);
    return {tg[8:0], st[2:0], wd[1:0], 2'b00};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    dly = 0;
    for (int i = 0; i < 1024; i++) begin
      ref_mem[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
      dram[i] = ref_mem[i];
    end
    for (int i = 0; i < 8; i++) begin
      m_lru[i] = 0;
      for (int w = 0; w < 2; w++) begin m_val[i][w] = 0; m_dirty[i][w] = 0; m_tag[i][w] = '0; end
    end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R10: nothing outstanding after reset
    check(cpu_ready == 0 && mem_req == 0, "R10 reset outputs", {cpu_ready, mem_req}, 0);
    access(0, mk(1, 2, 0), 0, 0);               // R10 first access misses
    access(0, mk(2, 2, 1), 0, 0);               // fills other way
    access(0, mk(1, 2, 3), 0, 0);               // hit, makes tag 1 recent
    access(0, mk(3, 2, 2), 0, 0);               // R4 evicts tag 2
    access(0, mk(1, 2, 1), 0, 0);               // R4 tag 1 still present
    access(0, mk(2, 2, 0), 0, 0);               // R4 tag 2 misses again
    access(1, mk(1, 2, 1), 32'hCAFEF00D, 4'b1111); // R5 store hit
    access(1, mk(5, 5, 2), 32'h11223344, 4'b0101); // R7 R8 store miss, partial
    access(0, mk(5, 5, 2), 0, 0);               // R8 merged bytes read back
    access(1, mk(5, 5, 3), 32'hA5A5A5A5, 4'b1000); // R8 partial store hit
    access(0, mk(6, 5, 0), 0, 0);
    access(0, mk(7, 5, 0), 0, 0);               // R6 dirty eviction
    access(0, mk(3, 2, 0), 0, 0);
    access(0, mk(4, 2, 0), 0, 0);               // R6 evicts dirty tag 1
    access(0, mk(1, 2, 1), 0, 0);               // R6 reload shows stored word
    for (int n = 0; n < 400; n++)
      access($urandom % 2, mk($urandom % 16, $urandom % 8, $urandom % 4),
             $urandom, 4'($urandom));
    finish_run();
  end
endmodule